// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register slave of a shared-memory peer device. A 256-byte window holds four words: an interrupt mask, an interrupt status, this node's own peer number (read-only) and a doorbell (write-only). Software rings another peer by writing the doorbell with a destination peer number and a vector number. The block checks the pair against a table of vector counts, one entry per peer. It emits a one-cycle notify strobe only when the pair is valid.

Local vector events arrive on a side input. In level mode an event loads the status word with the value 1. The interrupt line follows the masked status. In message mode the block instead raises a one-cycle message request per vector. A vector whose message mask is set keeps a pending bit, and the message goes out when that vector is unmasked. Reading the status word returns its value and clears it in the same access. The peer vector-count table is loaded through a separate write port indexed by peer number.

Top module: `bell_irq_regs`

## Requirements
- R1: After reset the mask word, the status word, every entry of the vector-count table, the pending bits, `irq`, `notify_valid` and `msg_req` are all zero.
- R2: A write replaces the whole 32-bit mask word (word index 0) or status word (word index 1). Writes decode the word index from `addr[7:2]`, so address bits 1:0 are ignored.
- R3: A read at exactly byte address 0, 4 or 8 returns the mask, the status or `self_id` (zero-extended) on `rdata` in the same cycle. Any other read address, including 12 and misaligned addresses, returns zero, and `rdata` is zero when `rd_en` is low. A status read clears the status word at the end of the access.
- R4: In level mode (`msg_mode`=0) with `pin_cfg`=1, `irq` is high exactly when (status AND mask) is nonzero, evaluated from the register values after each clock edge.
- R5: `irq` stays low whenever `msg_mode`=1 or `pin_cfg`=0.
- R6: A write to word index 3 carries the destination peer in `wdata[31:16]` and the vector in `wdata[7:0]`; bits 15:8 are ignored. An accepted doorbell raises `notify_valid` for exactly one cycle, in the cycle after the write, with `notify_peer` and `notify_vec` holding the decoded fields.
- R7: A doorbell is dropped, with no strobe, when the destination is not below `PEERS` or when the vector is not below the destination's table entry. The table entry for `cnt_peer` takes `cnt_val` on a clock edge with `cnt_we`=1. A doorbell in that same cycle uses the old entry.
- R8: In level mode, any nonzero `vec_evt` loads the status word with 1. This takes priority over a same-cycle status write or status read-clear.
- R9: In message mode with `msg_en`=1, an event on an unmasked vector raises that bit of `msg_req` for one cycle in the next cycle. With `msg_en`=0, events in message mode change nothing.
- R10: In message mode with `msg_en`=1, an event on a vector whose `vec_mask` bit is 1 sets its `msg_pend` bit and sends nothing. When a pending vector's mask bit falls from 1 to 0, its request is raised in the next cycle and the pending bit clears.
- R11: Writes to word indices other than 0, 1 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| self_id | input | 16 | This node's own peer number |
| msg_mode | input | 1 | 1 selects per-vector messages, 0 selects the level line |
| msg_en | input | 1 | Message delivery enabled |
| pin_cfg | input | 1 | Interrupt pin configured (nonzero) |
| cnt_we | input | 1 | Vector-count table write strobe |
| cnt_peer | input | PIDX_W | Table entry to write |
| cnt_val | input | 9 | Vector count for that peer |
| vec_evt | input | VECTORS | Local vector events, one bit per vector |
| vec_mask | input | VECTORS | Per-vector message mask |
| irq | output | 1 | Level interrupt line |
| notify_valid | output | 1 | Doorbell notify strobe |
| notify_peer | output | 16 | Destination peer of the strobe |
| notify_vec | output | 8 | Vector of the strobe |
| msg_req | output | VECTORS | Per-vector message request pulses |
| msg_pend | output | VECTORS | Per-vector pending bits |

## Verification
The bench builds the block with four peers and four vectors. With these values, random doorbell destinations cross the peer limit often, and random table counts of 0 to 5 against random vectors of 0 to 6 exercise both sides of the vector check. Mask, event and mode changes come often enough that pending bits are set, held and released by unmasking, including in the same cycle as new events. Misaligned and undefined addresses are in the address mix, which exposes the asymmetry between write decoding and read decoding.

// File: rtl/bell_irq_regs.sv
module bell_irq_regs #(
  parameter int ADDR_W  = 8,
  parameter int PEERS   = 16,
  parameter int VECTORS = 4,
  localparam int PIDX_W = (PEERS > 1) ? $clog2(PEERS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [15:0]        self_id,
  input  logic               msg_mode,
  input  logic               msg_en,
  input  logic               pin_cfg,
  input  logic               cnt_we,
  input  logic [PIDX_W-1:0]  cnt_peer,
  input  logic [8:0]         cnt_val,
  input  logic [VECTORS-1:0] vec_evt,
  input  logic [VECTORS-1:0] vec_mask,
  output logic               irq,
  output logic               notify_valid,
  output logic [15:0]        notify_peer,
  output logic [7:0]         notify_vec,
  output logic [VECTORS-1:0] msg_req,
  output logic [VECTORS-1:0] msg_pend
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_MASK = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_ID   = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_BELL = WORD_W'(3);

  logic [31:0]        mask_q, stat_q;
  logic [8:0]         cnt_tab [PEERS];
  logic [VECTORS-1:0] pend_q, vmask_q, req_q;
  logic               nv_q;
  logic [15:0]        np_q;
  logic [7:0]         nvec_q;

  wire [WORD_W-1:0] wword = addr[ADDR_W-1:2];
  wire wr_mask = wr_en && (wword == W_MASK);
  wire wr_stat = wr_en && (wword == W_STAT);
  wire wr_bell = wr_en && (wword == W_BELL);
  wire rd_stat = rd_en && (addr == {W_STAT, 2'b00});

  wire [15:0]       bell_dest = wdata[31:16];
  wire [7:0]        bell_vec  = wdata[7:0];
  wire              dest_ok   = bell_dest < 16'(PEERS);
  wire [PIDX_W-1:0] dest_idx  = bell_dest[PIDX_W-1:0];
  wire [8:0]        dest_cnt  = dest_ok ? cnt_tab[dest_idx] : 9'd0;
  wire              bell_fire = wr_bell && dest_ok && ({1'b0, bell_vec} < dest_cnt);

  wire                lvl_evt     = !msg_mode && (vec_evt != '0);
  wire [VECTORS-1:0]  msg_on      = {VECTORS{msg_mode && msg_en}};
  wire [VECTORS-1:0]  unmask_fire = msg_on & vmask_q & ~vec_mask & pend_q;
  wire [VECTORS-1:0]  send_now    = (msg_on & vec_evt & ~vec_mask) | unmask_fire;
  wire [VECTORS-1:0]  park        = msg_on & vec_evt & vec_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (wr_mask)  mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_q <= '0;
    else if (lvl_evt)  stat_q <= 32'd1;
    else if (wr_stat)  stat_q <= wdata;
    else if (rd_stat)  stat_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PEERS; p++) cnt_tab[p] <= '0;
    end else if (cnt_we) begin
      cnt_tab[cnt_peer] <= cnt_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q   <= 1'b0;
      np_q   <= '0;
      nvec_q <= '0;
    end else begin
      nv_q <= bell_fire;
      if (bell_fire) begin
        np_q   <= bell_dest;
        nvec_q <= bell_vec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      vmask_q <= '0;
      req_q   <= '0;
    end else begin
      pend_q  <= (pend_q & ~unmask_fire) | park;
      vmask_q <= vec_mask;
      req_q   <= send_now;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == {W_MASK, 2'b00})      rdata = mask_q;
      else if (addr == {W_STAT, 2'b00}) rdata = stat_q;
      else if (addr == {W_ID, 2'b00})   rdata = {16'd0, self_id};
    end
  end

  assign irq          = !msg_mode && pin_cfg && ((stat_q & mask_q) != '0);
  assign notify_valid = nv_q;
  assign notify_peer  = np_q;
  assign notify_vec   = nvec_q;
  assign msg_req      = req_q;
  assign msg_pend     = pend_q;
endmodule

module bell_irq_regs_chk #(
  parameter int ADDR_W  = 8,
  parameter int PEERS   = 16,
  parameter int VECTORS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wdata,
  input logic               msg_mode,
  input logic               msg_en,
  input logic [VECTORS-1:0] vec_evt,
  input logic               irq,
  input logic               notify_valid,
  input logic [15:0]        notify_peer,
  input logic [VECTORS-1:0] msg_req,
  input logic [31:0]        stat_q
);
  assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == ADDR_W'(4) && (msg_mode || vec_evt == '0)) |=> (stat_q == 32'd0));

  assert_mask_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1:2] == '0 && wdata == 32'd0) |=> !irq);

  assert_bell_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(3)));

  assert_bell_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (notify_peer < 16'(PEERS)));

  assert_lvl_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_mode && vec_evt != '0) |=> (stat_q == 32'd1));

  assert_req_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req != '0) |-> $past(msg_mode && msg_en));
endmodule

bind bell_irq_regs bell_irq_regs_chk #(.ADDR_W(ADDR_W), .PEERS(PEERS), .VECTORS(VECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .msg_mode(msg_mode), .msg_en(msg_en), .vec_evt(vec_evt), .irq(irq),
  .notify_valid(notify_valid), .notify_peer(notify_peer), .msg_req(msg_req), .stat_q(stat_q)
);

// File: tb/test_bell_irq_regs.sv
module test_bell_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 8;
  localparam int PEERS   = 4;
  localparam int VECTORS = 4;
  localparam int PIDX_W  = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] self_id = 16'h0002;
  logic msg_mode = 0, msg_en = 0, pin_cfg = 1;
  logic cnt_we = 0;
  logic [PIDX_W-1:0] cnt_peer = '0;
  logic [8:0] cnt_val = '0;
  logic [VECTORS-1:0] vec_evt = '0, vec_mask = '0;
  logic irq, notify_valid;
  logic [15:0] notify_peer;
  logic [7:0] notify_vec;
  logic [VECTORS-1:0] msg_req, msg_pend;

  int tests = 0, fails = 0;
  bit done = 0;

  bell_irq_regs #(.ADDR_W(ADDR_W), .PEERS(PEERS), .VECTORS(VECTORS)) i_bell_irq_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .self_id(self_id), .msg_mode(msg_mode), .msg_en(msg_en), .pin_cfg(pin_cfg),
    .cnt_we(cnt_we), .cnt_peer(cnt_peer), .cnt_val(cnt_val), .vec_evt(vec_evt),
    .vec_mask(vec_mask), .irq(irq), .notify_valid(notify_valid), .notify_peer(notify_peer),
    .notify_vec(notify_vec), .msg_req(msg_req), .msg_pend(msg_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_mask, m_stat;
  int          m_cnt [PEERS];
  logic [VECTORS-1:0] m_pend, m_vprev, m_req, oldp;
  logic        m_nv;
  logic [15:0] m_np;
  logic [7:0]  m_nvec;
  int          dest, vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_pend = 0; m_vprev = 0; m_req = 0;
      m_nv = 0; m_np = 0; m_nvec = 0;
      for (int p = 0; p < PEERS; p++) m_cnt[p] = 0;
    end else begin
      m_nv = 0; m_req = 0;
      if (rd_en && addr == 8'd4) m_stat = 0;
      if (wr_en) begin
        case (addr >> 2)
          0: m_mask = wdata;
          1: m_stat = wdata;
          3: begin
            dest = int'(wdata[31:16]); vec = int'(wdata[7:0]);
            if (dest < PEERS && vec < m_cnt[dest]) begin
              m_nv = 1; m_np = wdata[31:16]; m_nvec = wdata[7:0];
            end
          end
          default: ;
        endcase
      end
      if (cnt_we) m_cnt[cnt_peer] = int'(cnt_val);
      if (!msg_mode && vec_evt != 0) m_stat = 1;
      if (msg_mode && msg_en) begin
        oldp = m_pend;
        for (int v = 0; v < VECTORS; v++) begin
          if (vec_evt[v]) begin
            if (vec_mask[v]) m_pend[v] = 1; else m_req[v] = 1;
          end
          if (m_vprev[v] && !vec_mask[v] && oldp[v]) begin
            m_req[v] = 1; m_pend[v] = 0;
          end
        end
      end
      m_vprev = vec_mask;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [31:0] e_rd;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      e_rd = 0;
      if (rd_en) begin
        if (addr == 8'd0) e_rd = m_mask;
        else if (addr == 8'd4) e_rd = m_stat;
        else if (addr == 8'd8) e_rd = {16'd0, self_id};
      end
      chk("R3 rdata vs model", rdata, e_rd);
      chk("R4 R5 irq vs model", {31'd0, irq}, {31'd0, !msg_mode && pin_cfg && ((m_mask & m_stat) != 0)});
      chk("R6 notify_valid vs model", {31'd0, notify_valid}, {31'd0, m_nv});
      if (m_nv) chk("R6 notify fields vs model", {8'd0, notify_peer, notify_vec}, {8'd0, m_np, m_nvec});
      chk("R9 msg_req vs model", 32'(msg_req), 32'(m_req));
      chk("R10 msg_pend vs model", 32'(msg_pend), 32'(m_pend));
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; tick; wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a; #1 d = rdata; tick; rd_en = 0;
  endtask

  task automatic set_cnt(input int p, input int n);
    cnt_we = 1; cnt_peer = PIDX_W'(p); cnt_val = 9'(n); tick; cnt_we = 0;
  endtask

  task automatic evt(input logic [VECTORS-1:0] e);
    vec_evt = e; tick; vec_evt = 0;
  endtask

  logic [31:0] d;
  logic [7:0] amix [8] = '{8'd0, 8'd4, 8'd8, 8'd12, 8'd1, 8'd6, 8'd14, 8'h20};

  initial begin
    repeat (3) tick;
    rst_n = 1; tick;
    rd(8'd0, d); chk("R1 mask after reset", d, 0);
    rd(8'd4, d); chk("R1 status after reset", d, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);
    chk("R1 pend after reset", 32'(msg_pend), 0);
    chk("R1 notify after reset", {31'd0, notify_valid}, 0);
    wr(8'd12, 32'h0000_0000); chk("R1 empty count table drops doorbell", {31'd0, notify_valid}, 0);

    wr(8'd1, 32'h0000_0005); rd(8'd0, d); chk("R2 misaligned write reaches mask", d, 5);
    rd(8'd1, d); chk("R3 misaligned read is zero", d, 0);
    wr(8'd4, 32'h4); chk("R4 irq on masked status", {31'd0, irq}, 1);
    wr(8'd0, 32'h3); chk("R4 irq low without overlap", {31'd0, irq}, 0);
    wr(8'd0, 32'h5);
    pin_cfg = 0; #1 chk("R5 irq low with pin zero", {31'd0, irq}, 0);
    pin_cfg = 1; msg_mode = 1; #1 chk("R5 irq low in message mode", {31'd0, irq}, 0);
    msg_mode = 0;
    rd(8'd4, d); chk("R3 status read value", d, 4);
    rd(8'd4, d); chk("R3 status cleared by read", d, 0);
    chk("R4 irq drops after clear", {31'd0, irq}, 0);
    rd(8'd8, d); chk("R3 own id read", d, 32'h2);
    rd(8'd12, d); chk("R3 doorbell reads zero", d, 0);
    rd(8'h40, d); chk("R3 undefined reads zero", d, 0);

    set_cnt(2, 3); set_cnt(1, 0);
    wr(8'd12, 32'h0002_AB01);
    chk("R6 notify strobe", {31'd0, notify_valid}, 1);
    chk("R6 notify fields", {8'd0, notify_peer, notify_vec}, 32'h0000_0201);
    tick; chk("R6 strobe lasts one cycle", {31'd0, notify_valid}, 0);
    wr(8'd12, 32'h0002_0003); chk("R7 vector equal to count dropped", {31'd0, notify_valid}, 0);
    wr(8'd12, 32'h0001_0000); chk("R7 zero count dropped", {31'd0, notify_valid}, 0);
    wr(8'd12, 32'h0004_0000); chk("R7 destination out of range", {31'd0, notify_valid}, 0);
    wr(8'd12, 32'h0002_0002); chk("R7 last valid vector", {8'd0, notify_peer, notify_vec}, 32'h0000_0202);
    cnt_we = 1; cnt_peer = 2'd3; cnt_val = 9'd1;
    wr(8'd12, 32'h0003_0000); cnt_we = 0;
    chk("R7 same-cycle table write uses old entry", {31'd0, notify_valid}, 0);

    wr(8'h10, 32'hFFFF); rd(8'd0, d); chk("R11 undefined write leaves mask", d, 5);
    wr(8'hFC, 32'hFFFF); rd(8'd4, d); chk("R11 undefined write leaves status", d, 0);

    evt(4'b0010); rd(8'd4, d); chk("R8 level event sets status one", d, 1);
    vec_evt = 4'b0001; wr(8'd4, 32'hF0); vec_evt = 0;
    rd(8'd4, d); chk("R8 event beats status write", d, 1);

    msg_mode = 1; msg_en = 1; vec_mask = 4'b0100;
    evt(4'b0010); chk("R9 unmasked event sends", 32'(msg_req), 32'h2);
    tick; chk("R9 request lasts one cycle", 32'(msg_req), 0);
    evt(4'b0100); chk("R10 masked event sends nothing", 32'(msg_req), 0);
    chk("R10 masked event sets pending", 32'(msg_pend), 32'h4);
    vec_mask = 4'b0000; tick;
    chk("R10 unmask releases message", 32'(msg_req), 32'h4);
    chk("R10 unmask clears pending", 32'(msg_pend), 0);
    msg_en = 0; evt(4'b0001);
    chk("R9 disabled delivery sends nothing", 32'(msg_req), 0);
    chk("R9 disabled delivery sets no pending", 32'(msg_pend), 0);

    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 3 == 0);
      rd_en = ($urandom % 3 == 0);
      addr = amix[$urandom % 8];
      if (addr == 8'd12 || addr == 8'd14)
        wdata = {16'($urandom % 6), 8'($urandom), 8'($urandom % 7)};
      else
        wdata = $urandom & 32'hF;
      cnt_we = ($urandom % 6 == 0);
      cnt_peer = PIDX_W'($urandom);
      cnt_val = 9'($urandom % 6);
      vec_evt = ($urandom % 3 == 0) ? VECTORS'($urandom) : '0;
      if ($urandom % 5 == 0) vec_mask = VECTORS'($urandom);
      if ($urandom % 60 == 0) msg_mode = ~msg_mode;
      if ($urandom % 20 == 0) msg_en = ~msg_en;
      if ($urandom % 40 == 0) pin_cfg = ~pin_cfg;
      tick;
    end
    wr_en = 0; rd_en = 0; vec_evt = 0; cnt_we = 0;
    tick; tick;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule